// File: doc/BRIEF.md
# Pipeline Program Counter Tracker with Freeze Buffer

This block follows instruction addresses through a three-stage decode, execute and write-back pipeline. The pipeline has one branch delay slot, so the instruction after a branch always executes. Three live registers hold the address in decode, the address in execute and the address of the instruction that has just left execute. A pipeline step strobe moves every address one stage on. On each step the decode address either advances sequentially or, when a branch is resolved as taken, loads the branch target. At that point the delay-slot instruction moves into execute.

When a trap or interrupt is taken, the block copies a snapshot of the addresses into a three-entry restart buffer. Software later uses this buffer to resume the interrupted stream. The snapshot depends on the trap class. A synchronous fault records the faulting instruction as the execute entry. An asynchronous interrupt or an instruction trap records the next instruction in program order as the execute entry. The live registers keep running while this happens. A special-register port lets handler code read any buffer entry and overwrite it before the restart.

Top module: `pc_track`

## Requirements
- R1: While reset is asserted, the decode address is RST_PC (default 0x100), and the execute address, the write-back address and all three restart-buffer entries are zero.
- R2: On a step with no branch taken, the decode address increases by STEP (default 4), wrapping modulo 2^AW.
- R3: On every step, the execute address takes the previous decode address and the write-back address takes the previous execute address.
- R4: On a step with the branch-taken flag high, the decode address loads the branch target. The execute address then holds the delay-slot address, which was the previous decode address.
- R5: Without a step, all three live addresses hold, and the branch flag and target have no effect.
- R6: A synchronous trap (trap strobe high, class flag low) loads the buffer entries with the current decode, execute and write-back addresses. The execute entry is the faulting instruction.
- R7: An asynchronous trap (class flag high) loads the execute entry with the current decode address and the write-back entry with the current execute address. The decode entry gets the branch target if the branch flag is high, and otherwise the decode address plus STEP.
- R8: A trap does not stall the live registers. A step in the trap cycle still advances them.
- R9: The read data equals the buffer entry picked by the select input: 0 = decode entry, 1 = execute entry, 2 = write-back entry. Select value 3 reads zero.
- R10: A register-port write with select 0, 1 or 2 replaces that entry on the next clock edge. A write with select 3 changes no entry.
- R11: A trap strobe and a register-port write in the same cycle load the buffer from the trap capture, and the write is lost.
- R12: With no trap strobe and no write, the buffer entries hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Pipeline advance strobe |
| br_taken_i | input | 1 | Branch resolved taken in this step |
| br_target_i | input | AW | Branch target address |
| trap_i | input | 1 | Trap or interrupt taken this cycle |
| trap_async_i | input | 1 | 1 = asynchronous or instruction trap, 0 = synchronous fault |
| sr_wr_i | input | 1 | Register-port write enable |
| sr_sel_i | input | 2 | Buffer entry select (0 decode, 1 execute, 2 write-back) |
| sr_wdata_i | input | AW | Register-port write data |
| sr_rdata_o | output | AW | Register-port read data |
| dec_pc_o | output | AW | Live decode address |
| exe_pc_o | output | AW | Live execute address |
| wb_pc_o | output | AW | Live write-back address |
| frz_dec_o | output | AW | Frozen decode entry |
| frz_exe_o | output | AW | Frozen execute entry |
| frz_wb_o | output | AW | Frozen write-back entry |

## Verification
All state is visible at the ports, so a corrupted live register shows on its output one cycle after the faulty step. One and two further steps later, it spreads into the execute and write-back outputs. A wrong capture or write of the restart buffer shows on the frozen outputs and on the read data in the cycle after the edge. The bench cycles through every combination of step, branch, trap class, write and select several times, with changing addresses. Each such fault is therefore compared within one clock of its cause.

// File: rtl/pc_track_pkg.sv
package pc_track_pkg;
    localparam int unsigned N_ENT = 3;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DEC  = 2'd0,
        SEL_EXE  = 2'd1,
        SEL_WB   = 2'd2,
        SEL_NONE = 2'd3
    } ent_sel_e;
endpackage

// File: rtl/pc_live.sv
module pc_live #(
    parameter int unsigned AW     = 32,
    parameter int unsigned STEP   = 4,
    parameter logic [AW-1:0] RST_PC = 'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          br_taken_i,
    input  logic [AW-1:0] br_target_i,
    output logic [AW-1:0] dec_o,
    output logic [AW-1:0] exe_o,
    output logic [AW-1:0] wb_o,
    output logic [AW-1:0] dec_nxt_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    typedef struct packed {
        logic [AW-1:0] dec;
        logic [AW-1:0] exe;
        logic [AW-1:0] wb;
    } live_t;

    live_t         st_q, st_d;
    logic [AW-1:0] nxt_d;

    always_comb begin
        nxt_d = br_taken_i ? br_target_i : st_q.dec + STEP_V;
        st_d  = st_q;
        if (step_i) begin
            st_d.wb  = st_q.exe;
            st_d.exe = st_q.dec;
            st_d.dec = nxt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dec <= RST_PC;
            st_q.exe <= '0;
            st_q.wb  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_o     = st_q.dec;
    assign exe_o     = st_q.exe;
    assign wb_o      = st_q.wb;
    assign dec_nxt_o = nxt_d;
endmodule

// File: rtl/pc_frz.sv
module pc_frz
    import pc_track_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_i,
    input  logic             trap_async_i,
    input  logic [AW-1:0]    dec_i,
    input  logic [AW-1:0]    exe_i,
    input  logic [AW-1:0]    wb_i,
    input  logic [AW-1:0]    dec_nxt_i,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [AW-1:0]    wdata_i,
    output logic [AW-1:0]    rdata_o,
    output logic [AW-1:0]    ent_dec_o,
    output logic [AW-1:0]    ent_exe_o,
    output logic [AW-1:0]    ent_wb_o
);
    logic [N_ENT-1:0][AW-1:0] ent_q, ent_d;
    ent_sel_e                 sel;

    assign sel = ent_sel_e'(sel_i);

    always_comb begin
        ent_d = ent_q;
        if (trap_i) begin
            if (trap_async_i) begin
                ent_d[SEL_DEC] = dec_nxt_i;
                ent_d[SEL_EXE] = dec_i;
                ent_d[SEL_WB]  = exe_i;
            end else begin
                ent_d[SEL_DEC] = dec_i;
                ent_d[SEL_EXE] = exe_i;
                ent_d[SEL_WB]  = wb_i;
            end
        end else if (wr_i) begin
            for (int k = 0; k < N_ENT; k++) begin
                if (sel_i == SEL_W'(k)) ent_d[k] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    always_comb begin
        case (sel)
            SEL_DEC: rdata_o = ent_q[SEL_DEC];
            SEL_EXE: rdata_o = ent_q[SEL_EXE];
            SEL_WB:  rdata_o = ent_q[SEL_WB];
            default: rdata_o = '0;
        endcase
    end

    assign ent_dec_o = ent_q[SEL_DEC];
    assign ent_exe_o = ent_q[SEL_EXE];
    assign ent_wb_o  = ent_q[SEL_WB];
endmodule

// File: rtl/pc_track.sv
module pc_track
    import pc_track_pkg::*;
#(
    parameter int unsigned   AW     = 32,
    parameter int unsigned   STEP   = 4,
    parameter logic [AW-1:0] RST_PC = 'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             br_taken_i,
    input  logic [AW-1:0]    br_target_i,
    input  logic             trap_i,
    input  logic             trap_async_i,
    input  logic             sr_wr_i,
    input  logic [SEL_W-1:0] sr_sel_i,
    input  logic [AW-1:0]    sr_wdata_i,
    output logic [AW-1:0]    sr_rdata_o,
    output logic [AW-1:0]    dec_pc_o,
    output logic [AW-1:0]    exe_pc_o,
    output logic [AW-1:0]    wb_pc_o,
    output logic [AW-1:0]    frz_dec_o,
    output logic [AW-1:0]    frz_exe_o,
    output logic [AW-1:0]    frz_wb_o
);
    logic [AW-1:0] dec_nxt;

    pc_live #(.AW(AW), .STEP(STEP), .RST_PC(RST_PC)) u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .br_taken_i  (br_taken_i),
        .br_target_i (br_target_i),
        .dec_o       (dec_pc_o),
        .exe_o       (exe_pc_o),
        .wb_o        (wb_pc_o),
        .dec_nxt_o   (dec_nxt)
    );

    pc_frz #(.AW(AW)) u_frz (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_i       (trap_i),
        .trap_async_i (trap_async_i),
        .dec_i        (dec_pc_o),
        .exe_i        (exe_pc_o),
        .wb_i         (wb_pc_o),
        .dec_nxt_i    (dec_nxt),
        .wr_i         (sr_wr_i),
        .sel_i        (sr_sel_i),
        .wdata_i      (sr_wdata_i),
        .rdata_o      (sr_rdata_o),
        .ent_dec_o    (frz_dec_o),
        .ent_exe_o    (frz_exe_o),
        .ent_wb_o     (frz_wb_o)
    );
endmodule

// File: rtl/pc_track_chk.sv
module pc_track_chk #(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_i,
    input logic          br_taken_i,
    input logic [AW-1:0] br_target_i,
    input logic          trap_i,
    input logic          trap_async_i,
    input logic          sr_wr_i,
    input logic [1:0]    sr_sel_i,
    input logic [AW-1:0] sr_wdata_i,
    input logic [AW-1:0] sr_rdata_o,
    input logic [AW-1:0] dec_pc_o,
    input logic [AW-1:0] exe_pc_o,
    input logic [AW-1:0] wb_pc_o,
    input logic [AW-1:0] frz_dec_o,
    input logic [AW-1:0] frz_exe_o,
    input logic [AW-1:0] frz_wb_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !br_taken_i |=> dec_pc_o == $past(dec_pc_o) + STEP_V);

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> exe_pc_o == $past(dec_pc_o) && wb_pc_o == $past(exe_pc_o));

    p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && br_taken_i |=> dec_pc_o == $past(br_target_i));

    p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(dec_pc_o) && $stable(exe_pc_o) && $stable(wb_pc_o));

    p_sync_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && !trap_async_i |=> frz_exe_o == $past(exe_pc_o)
                                    && frz_dec_o == $past(dec_pc_o)
                                    && frz_wb_o == $past(wb_pc_o));

    p_async_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_i && trap_async_i |=> frz_exe_o == $past(dec_pc_o)
                                   && frz_wb_o == $past(exe_pc_o));

    p_frz_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_i && !sr_wr_i |=> $stable(frz_dec_o) && $stable(frz_exe_o) && $stable(frz_wb_o));

    p_sel_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_sel_i == 2'd3 |-> sr_rdata_o == '0);
endmodule

bind pc_track pc_track_chk #(.AW(AW), .STEP(STEP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .br_taken_i   (br_taken_i),
    .br_target_i  (br_target_i),
    .trap_i       (trap_i),
    .trap_async_i (trap_async_i),
    .sr_wr_i      (sr_wr_i),
    .sr_sel_i     (sr_sel_i),
    .sr_wdata_i   (sr_wdata_i),
    .sr_rdata_o   (sr_rdata_o),
    .dec_pc_o     (dec_pc_o),
    .exe_pc_o     (exe_pc_o),
    .wb_pc_o      (wb_pc_o),
    .frz_dec_o    (frz_dec_o),
    .frz_exe_o    (frz_exe_o),
    .frz_wb_o     (frz_wb_o)
);

// File: tb/pc_track_test.sv
`timescale 1ns/1ps
module pc_track_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          step_i, br_taken_i, trap_i, trap_async_i, sr_wr_i;
    logic [1:0]    sr_sel_i;
    logic [AW-1:0] br_target_i, sr_wdata_i;
    logic [AW-1:0] sr_rdata_o, dec_pc_o, exe_pc_o, wb_pc_o;
    logic [AW-1:0] frz_dec_o, frz_exe_o, frz_wb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] m_dec, m_exe, m_wb;
    logic [AW-1:0] m_f [3];
    logic [31:0]   lfsr = 32'hACE1_2357;

    always #2 clk = ~clk;

    pc_track uut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_taken_i(br_taken_i),
        .br_target_i(br_target_i), .trap_i(trap_i), .trap_async_i(trap_async_i),
        .sr_wr_i(sr_wr_i), .sr_sel_i(sr_sel_i), .sr_wdata_i(sr_wdata_i),
        .sr_rdata_o(sr_rdata_o), .dec_pc_o(dec_pc_o), .exe_pc_o(exe_pc_o),
        .wb_pc_o(wb_pc_o), .frz_dec_o(frz_dec_o), .frz_exe_o(frz_exe_o),
        .frz_wb_o(frz_wb_o)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nlfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic cycle(input logic a, input logic b, input logic t, input logic as,
                         input logic w, input logic [1:0] s,
                         input logic [AW-1:0] tg, input logic [AW-1:0] wd);
        logic [AW-1:0] nd, ne, nw, nxt;
        logic [AW-1:0] nf [3];
        string ltag, etag, ftag;
        step_i = a; br_taken_i = b; trap_i = t; trap_async_i = as;
        sr_wr_i = w; sr_sel_i = s; br_target_i = tg; sr_wdata_i = wd;
        nxt = b ? tg : m_dec + 32'd4;
        nd = m_dec; ne = m_exe; nw = m_wb;
        if (a) begin nd = nxt; ne = m_dec; nw = m_exe; end
        nf = m_f;
        if (t) begin
            if (as) begin nf[0] = nxt;   nf[1] = m_dec; nf[2] = m_exe; end
            else    begin nf[0] = m_dec; nf[1] = m_exe; nf[2] = m_wb;  end
        end else if (w && s != 2'd3) begin
            nf[s] = wd;
        end
        @(posedge clk);
        #1;
        m_dec = nd; m_exe = ne; m_wb = nw; m_f = nf;
        ltag = !a ? "R5 hold" : (t ? "R8 trap-step" : (b ? "R4 branch" : "R2 seq"));
        etag = !a ? "R5 hold" : (t ? "R8 trap-step" : "R3 shift");
        ftag = t ? (w ? "R11 trap-wins" : (as ? "R7 async" : "R6 sync"))
                 : (w ? (s == 2'd3 ? "R10 sel3-write" : "R10 write") : "R12 frz-hold");
        chk({ltag, " dec"}, dec_pc_o, m_dec);
        chk({etag, " exe"}, exe_pc_o, m_exe);
        chk({etag, " wb"},  wb_pc_o,  m_wb);
        chk({ftag, " fdec"}, frz_dec_o, m_f[0]);
        chk({ftag, " fexe"}, frz_exe_o, m_f[1]);
        chk({ftag, " fwb"},  frz_wb_o,  m_f[2]);
        chk("R9 rdata", sr_rdata_o, (s == 2'd3) ? '0 : m_f[s]);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        step_i = 0; br_taken_i = 0; trap_i = 0; trap_async_i = 0;
        sr_wr_i = 0; sr_sel_i = 0; br_target_i = '0; sr_wdata_i = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1 reset dec", dec_pc_o, 32'h100);
        chk("R1 reset exe", exe_pc_o, '0);
        chk("R1 reset wb",  wb_pc_o,  '0);
        chk("R1 reset fdec", frz_dec_o, '0);
        chk("R1 reset fexe", frz_exe_o, '0);
        chk("R1 reset fwb",  frz_wb_o,  '0);
        m_dec = 32'h100; m_exe = '0; m_wb = '0;
        m_f[0] = '0; m_f[1] = '0; m_f[2] = '0;
        rst_n = 1'b1;
        // directed: sequential steps, then branch with delay slot
        cycle(1,0,0,0,0,2'd0,'0,'0);
        cycle(1,0,0,0,0,2'd0,'0,'0);
        cycle(1,1,0,0,0,2'd1,32'h0000_2000,'0);
        chk("R4 delay slot in exe", exe_pc_o, 32'h108);
        // directed: sync trap then async trap
        cycle(0,0,1,0,0,2'd1,'0,'0);
        chk("R6 faulting addr", frz_exe_o, 32'h108);
        cycle(0,0,1,1,0,2'd1,'0,'0);
        chk("R7 next addr", frz_exe_o, 32'h2000);
        // directed: write to sel 3 changes nothing
        cycle(0,0,0,0,1,2'd3,'0,32'hDEAD_BEEF);
        // exhaustive sweep over control combinations with varying data
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 128; i++) begin
                logic [6:0] c;
                logic [AW-1:0] tg, wd;
                c = 7'(i);
                lfsr = nlfsr(lfsr); tg = {lfsr[31:2], 2'b00};
                lfsr = nlfsr(lfsr); wd = lfsr;
                cycle(c[0], c[1], c[2], c[3], c[4], c[6:5], tg, wd);
            end
        end
        // wrap of the sequential step at the top of the address space
        cycle(1,1,0,0,0,2'd0,32'hFFFF_FFFC,'0);
        cycle(1,0,0,0,0,2'd0,'0,'0);
        chk("R2 wrap", dec_pc_o, 32'h0000_0000);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule